// File: doc/BRIEF.md
# Debug Address Breakpoint Unit

This block keeps a small set of debug address slots, a control word and a status word, and compares the slots against the instruction fetch stream and against tagged data accesses. Each slot is set up as an instruction breakpoint or as a data watchpoint with its own byte length, and each slot has two enable bits. When a slot matches, the block records the match in the status word and asks the core for a debug exception one cycle later.

Software programs the slots through a plain register port. Reads are combinational. Writes take effect at the clock edge. The fetch and data-access inputs are valid-qualified streams that the block always accepts, so it never applies back-pressure: there is no ready output, and every cycle with a valid strobe is evaluated. A force input lets the core rewrite the status match bits even when no enabled slot matched.

Top module: `dbg_bp_unit`

## Requirements
- R1: After reset, every slot address reads 0, the status word reads 0xFFFF0FF0, the control word reads 0x00000400 and `exc_req` is low.
- R2: Register addresses 0 to 3 select slots 0 to 3, address 4 selects status and address 5 selects control. Addresses 6 and 7 read zero and ignore writes. A write to status stores the data ORed with 0xFFFF0FF0. A write to control stores the data ORed with 0x00000400.
- R3: A slot whose type field is 00 hits when `fetch_valid` is high and `fetch_addr` equals the slot address.
- R4: Type 01 hits only on data writes (`mem_write`=1). Type 11 hits on reads and on writes. Both require `mem_valid`.
- R5: The length code 00/01/11/10 selects a 1/2/4/8-byte watch range, aligned down to its own size. `mem_size` 0/1/2/3 gives an access of 1/2/4/8 bytes starting at `mem_addr`. A data slot hits when the two byte ranges overlap.
- R6: A slot whose type field is 10 never hits.
- R7: A status update replaces the low four bits of status with the per-slot hit vector, and disabled slots are included. The update is committed only when an enabled slot hit or `stat_force` is high. Otherwise status keeps its value.
- R8: `exc_req` is high for exactly the cycle after a cycle in which at least one enabled slot hit. `stat_force` alone never raises it.
- R9: Slot n is enabled when control bit 2n or 2n+1 is set. Its type sits in control bits 17+4n:16+4n and its length code in bits 19+4n:18+4n.
- R10: When a status update commits in the same cycle as a register write to status, the update wins and the written data is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for read and write |
| reg_wdata | input | XLEN | Register write data |
| reg_rdata | output | XLEN | Selected register value (combinational) |
| fetch_valid | input | 1 | Instruction pointer valid |
| fetch_addr | input | XLEN | Current instruction pointer |
| mem_valid | input | 1 | Data access valid |
| mem_addr | input | XLEN | Data access start byte address |
| mem_size | input | 2 | Access size as log2 of the byte count |
| mem_write | input | 1 | Access is a write |
| stat_force | input | 1 | Commit the status update even without an enabled hit |
| exc_req | output | 1 | Debug exception request |

## Verification
The assertions assume that the core holds the fetch and data inputs stable only within a cycle, and that `mem_size` never carries an access past the top of the address space. The stimulus keeps every address far from the top of the range, so the overlap arithmetic stays valid. The properties also assume that the register port and the evaluation inputs are known after reset. The bench drives every input in every cycle, including idle cycles with the strobes low.

// File: rtl/dbg_bp_pkg.sv
package dbg_bp_pkg;

  typedef enum logic [1:0] {
    BP_EXEC = 2'b00,
    BP_WR   = 2'b01,
    BP_IO   = 2'b10,
    BP_RW   = 2'b11
  } bp_kind_e;

  localparam logic [2:0]  REG_STAT  = 3'd4;
  localparam logic [2:0]  REG_CTRL  = 3'd5;
  localparam logic [31:0] STAT_ONES = 32'hFFFF_0FF0;
  localparam logic [31:0] CTRL_ONES = 32'h0000_0400;

  // Watch length code to byte count: 00=1, 01=2, 11=4, 10=8
  function automatic logic [3:0] len_bytes(input logic [1:0] code);
    logic [3:0] b;
    unique case (code)
      2'b00:   b = 4'd1;
      2'b01:   b = 4'd2;
      2'b11:   b = 4'd4;
      default: b = 4'd8;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/dbg_bp_regs.sv
module dbg_bp_regs
  import dbg_bp_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int NUM_SLOTS = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_wr,
  input  logic [2:0]                      reg_addr,
  input  logic [XLEN-1:0]                 reg_wdata,
  output logic [XLEN-1:0]                 reg_rdata,
  input  logic                            commit,
  input  logic [NUM_SLOTS-1:0]            hit_vec,
  output logic [NUM_SLOTS-1:0][XLEN-1:0]  slot_addr,
  output logic [NUM_SLOTS-1:0][1:0]       slot_kind,
  output logic [NUM_SLOTS-1:0][1:0]       slot_len,
  output logic [NUM_SLOTS-1:0]            slot_en,
  output logic [NUM_SLOTS-1:0]            stat_hits
);

  localparam logic [XLEN-1:0] STAT_RST = XLEN'(STAT_ONES);
  localparam logic [XLEN-1:0] CTRL_RST = XLEN'(CTRL_ONES);

  logic [NUM_SLOTS-1:0][XLEN-1:0] slot_q;
  logic [XLEN-1:0] ctrl_q;
  logic [XLEN-1:0] stat_q;
  logic            stat_wr;

  assign stat_wr = reg_wr && (reg_addr == REG_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      ctrl_q <= CTRL_RST;
      stat_q <= STAT_RST;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (reg_wr && (reg_addr == 3'(i))) slot_q[i] <= reg_wdata;
      end
      if (reg_wr && (reg_addr == REG_CTRL)) ctrl_q <= reg_wdata | CTRL_RST;
      // A committed evaluation takes priority over a software write
      if (commit)       stat_q[NUM_SLOTS-1:0] <= hit_vec;
      else if (stat_wr) stat_q <= reg_wdata | STAT_RST;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (reg_addr == 3'(i)) reg_rdata = slot_q[i];
    end
    if (reg_addr == REG_STAT) reg_rdata = stat_q;
    if (reg_addr == REG_CTRL) reg_rdata = ctrl_q;
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_fields
    assign slot_en[g]   = |ctrl_q[2*g +: 2];
    assign slot_kind[g] = ctrl_q[16+4*g +: 2];
    assign slot_len[g]  = ctrl_q[18+4*g +: 2];
  end

  assign slot_addr = slot_q;
  assign stat_hits = stat_q[NUM_SLOTS-1:0];

  AST_STAT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & STAT_RST) == STAT_RST); // R1
  AST_CTRL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & CTRL_RST) == CTRL_RST); // R2
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !stat_wr) |=> $stable(stat_q)); // R7

endmodule

// File: rtl/dbg_bp_slot.sv
module dbg_bp_slot
  import dbg_bp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] slot_addr,
  input  logic [1:0]      kind,
  input  logic [1:0]      len_code,
  input  logic            fetch_valid,
  input  logic [XLEN-1:0] fetch_addr,
  input  logic            mem_valid,
  input  logic [XLEN-1:0] mem_addr,
  input  logic [1:0]      mem_size,
  input  logic            mem_write,
  output logic            hit
);

  localparam int AW = XLEN + 1;

  bp_kind_e        kind_e;
  logic [XLEN-1:0] len_x;
  logic [AW-1:0]   w_lo, w_hi, a_lo, a_hi;
  logic            ovl;

  assign kind_e = bp_kind_e'(kind);
  assign len_x  = XLEN'(len_bytes(len_code));
  assign w_lo   = {1'b0, slot_addr & ~(len_x - XLEN'(1))};
  assign w_hi   = w_lo + AW'(len_x);
  assign a_lo   = {1'b0, mem_addr};
  assign a_hi   = a_lo + (AW'(1) << mem_size);
  assign ovl    = (a_lo < w_hi) && (w_lo < a_hi);

  always_comb begin
    unique case (kind_e)
      BP_EXEC: hit = fetch_valid && (fetch_addr == slot_addr);
      BP_WR:   hit = mem_valid && mem_write && ovl;
      BP_RW:   hit = mem_valid && ovl;
      default: hit = 1'b0;
    endcase
  end

  AST_IO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_e == BP_IO) |-> !hit); // R6
  AST_WR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_e == BP_WR && !mem_write) |-> !hit); // R4

endmodule

// File: rtl/dbg_bp_eval.sv
module dbg_bp_eval #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] hit_vec,
  input  logic [NUM_SLOTS-1:0] slot_en,
  input  logic                 stat_force,
  output logic                 commit,
  output logic                 exc_req
);

  logic en_hit;

  assign en_hit = |(hit_vec & slot_en);
  assign commit = en_hit || stat_force;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exc_req <= 1'b0;
    else        exc_req <= en_hit;
  end

  AST_EXC_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> $past(commit)); // R8

endmodule

// File: rtl/dbg_bp_unit.sv
module dbg_bp_unit
  import dbg_bp_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int NUM_SLOTS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [XLEN-1:0] reg_wdata,
  output logic [XLEN-1:0] reg_rdata,
  input  logic            fetch_valid,
  input  logic [XLEN-1:0] fetch_addr,
  input  logic            mem_valid,
  input  logic [XLEN-1:0] mem_addr,
  input  logic [1:0]      mem_size,
  input  logic            mem_write,
  input  logic            stat_force,
  output logic            exc_req
);

  logic [NUM_SLOTS-1:0][XLEN-1:0] slot_addr;
  logic [NUM_SLOTS-1:0][1:0]      slot_kind;
  logic [NUM_SLOTS-1:0][1:0]      slot_len;
  logic [NUM_SLOTS-1:0]           slot_en;
  logic [NUM_SLOTS-1:0]           hit_vec;
  logic [NUM_SLOTS-1:0]           stat_hits;
  logic                           commit;

  dbg_bp_regs #(.XLEN(XLEN), .NUM_SLOTS(NUM_SLOTS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .commit(commit), .hit_vec(hit_vec),
    .slot_addr(slot_addr), .slot_kind(slot_kind), .slot_len(slot_len),
    .slot_en(slot_en), .stat_hits(stat_hits)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    dbg_bp_slot #(.XLEN(XLEN)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .slot_addr(slot_addr[g]), .kind(slot_kind[g]), .len_code(slot_len[g]),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
      .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_write(mem_write), .hit(hit_vec[g])
    );
  end

  dbg_bp_eval #(.NUM_SLOTS(NUM_SLOTS)) u_eval (
    .clk(clk), .rst_n(rst_n),
    .hit_vec(hit_vec), .slot_en(slot_en), .stat_force(stat_force),
    .commit(commit), .exc_req(exc_req)
  );

  AST_EXC_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (stat_hits != '0)); // R8

endmodule

// File: tb/tb_dbg_bp_unit.sv
module tb_dbg_bp_unit;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_addr = '0;
  logic [1:0]  mem_size = '0;
  logic        mem_write = 1'b0;
  logic        stat_force = 1'b0;
  logic        exc_req;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_slot [4];
  logic [31:0] m_ctrl, m_stat;
  logic        m_exc;

  always #(CLK_P/2) clk = ~clk;

  dbg_bp_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_write(mem_write), .stat_force(stat_force), .exc_req(exc_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [2:0] a);
    if (a < 3'd4) return m_slot[a[1:0]];
    if (a == 3'd4) return m_stat;
    if (a == 3'd5) return m_ctrl;
    return 32'h0;
  endfunction

  function automatic bit m_hit(input int n, input bit fv, input logic [31:0] fa,
                               input bit mv, input logic [31:0] ma,
                               input logic [1:0] ms, input bit mw);
    int t = int'((m_ctrl >> (16 + 4*n)) & 32'h3);
    int lc = int'((m_ctrl >> (18 + 4*n)) & 32'h3);
    longint len = (lc == 0) ? 1 : (lc == 1) ? 2 : (lc == 3) ? 4 : 8;
    longint sa = longint'(m_slot[n]);
    longint base = sa - (sa % len);
    longint a = longint'(ma);
    longint sz = longint'(1) << ms;
    if (t == 0) return fv && (m_slot[n] == fa);
    if (t == 2) return 1'b0;
    if (t == 1 && !mw) return 1'b0;
    return mv && (a < base + len) && (base < a + sz);
  endfunction

  task automatic cyc(input string tag, input bit wr, input logic [2:0] ra,
                     input logic [31:0] wd, input bit fv, input logic [31:0] fa,
                     input bit mv, input logic [31:0] ma, input logic [1:0] ms,
                     input bit mw, input bit frc);
    logic [3:0] h;
    bit en_hit, commit;
    reg_wr = wr; reg_addr = ra; reg_wdata = wd;
    fetch_valid = fv; fetch_addr = fa;
    mem_valid = mv; mem_addr = ma; mem_size = ms; mem_write = mw;
    stat_force = frc;
    #1;
    chk(tag, reg_rdata, m_read(ra));
    chk("R8", {31'b0, exc_req}, {31'b0, m_exc});
    en_hit = 1'b0;
    for (int n = 0; n < 4; n++) begin
      h[n] = m_hit(n, fv, fa, mv, ma, ms, mw);
      if (h[n] && (m_ctrl[2*n] || m_ctrl[2*n+1])) en_hit = 1'b1;
    end
    commit = en_hit || frc;
    if (wr) begin
      if (ra < 3'd4) m_slot[ra[1:0]] = wd;
      if (ra == 3'd5) m_ctrl = wd | 32'h0000_0400;
      if (ra == 3'd4 && !commit) m_stat = wd | 32'hFFFF_0FF0;
    end
    if (commit) m_stat[3:0] = h;
    m_exc = en_hit;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input string tag, input logic [2:0] ra);
    cyc(tag, 0, ra, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(input string tag, input logic [2:0] ra, input logic [31:0] wd);
    cyc(tag, 1, ra, wd, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic fetch(input string tag, input logic [31:0] fa, input bit frc);
    cyc(tag, 0, 3'd4, 0, 1, fa, 0, 0, 0, 0, frc);
  endtask

  task automatic acc(input string tag, input logic [31:0] ma, input logic [1:0] ms, input bit mw);
    cyc(tag, 0, 3'd4, 0, 0, 0, 1, ma, ms, mw, 0);
  endtask

  initial begin
    #(CLK_P * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_slot[i] = '0;
    m_ctrl = 32'h0000_0400; m_stat = 32'hFFFF_0FF0; m_exc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values of every register
    for (int a = 0; a < 8; a++) rd("R1", 3'(a));

    // R2 fixed-one bits and unused addresses
    wr("R2", 3'd4, 32'h0);          rd("R2", 3'd4);
    wr("R2", 3'd4, 32'h0000_F00F);  rd("R2", 3'd4);
    wr("R2", 3'd5, 32'h0);          rd("R2", 3'd5);
    wr("R2", 3'd6, 32'hDEAD_BEEF);  rd("R2", 3'd6); rd("R2", 3'd7);
    wr("R2", 3'd4, 32'h0);

    // R3 / R9 instruction breakpoint in slot 0, local enable
    wr("R9", 3'd0, 32'h0000_1000);
    wr("R9", 3'd5, 32'h0000_0001);
    fetch("R3", 32'h0000_1000, 0);
    rd("R3", 3'd4);
    fetch("R3", 32'h0000_1004, 0);
    rd("R3", 3'd4);

    // R4 / R5 slot 1: write-only, 4-byte range at 0x2000, global enable
    wr("R9", 3'd1, 32'h0000_2003);
    wr("R9", 3'd5, 32'h00D0_0009);
    acc("R4", 32'h0000_2000, 2'd2, 0); rd("R4", 3'd4);
    acc("R4", 32'h0000_2001, 2'd0, 1); rd("R4", 3'd4);
    acc("R5", 32'h0000_2004, 2'd0, 1); rd("R5", 3'd4);
    acc("R5", 32'h0000_1FFC, 2'd3, 1); rd("R5", 3'd4);
    acc("R5", 32'h0000_1FFE, 2'd1, 1); rd("R5", 3'd4);
    // R4 switch slot 1 to read/write, 8-byte code 10
    wr("R4", 3'd5, 32'h00B0_0009);
    acc("R4", 32'h0000_2007, 2'd0, 0); rd("R4", 3'd4);

    // R6 slot 2 configured as I/O type and enabled
    wr("R6", 3'd2, 32'h0000_1000);
    wr("R6", 3'd5, 32'h02D0_0019);
    fetch("R6", 32'h0000_1000, 0); rd("R6", 3'd4);

    // R7 disabled slot 3 matching alongside enabled slot 0
    wr("R7", 3'd3, 32'h0000_1000);
    fetch("R7", 32'h0000_1000, 0); rd("R7", 3'd4);
    wr("R7", 3'd4, 32'h0);
    wr("R7", 3'd5, 32'h02D0_0018);
    fetch("R7", 32'h0000_1000, 0); rd("R7", 3'd4);
    fetch("R7", 32'h0000_1000, 1); rd("R7", 3'd4);
    fetch("R7", 32'h0000_5000, 1); rd("R7", 3'd4);

    // R10 status write collides with a committed update
    wr("R10", 3'd5, 32'h02D0_0019);
    wr("R10", 3'd4, 32'h0);
    cyc("R10", 1, 3'd4, 32'h0000_F000, 1, 32'h0000_1000, 0, 0, 0, 0, 0);
    rd("R10", 3'd4);

    // Mixed stimulus against the model
    for (int k = 0; k < 400; k++) begin
      bit w = ($urandom % 4) == 0;
      logic [2:0] ra = 3'($urandom % 8);
      logic [31:0] wd;
      if (ra == 3'd5)      wd = $urandom;
      else if (ra < 3'd4)  wd = 32'h1000 + ($urandom % 16);
      else                 wd = $urandom;
      cyc("R7", w, ra, wd,
          ($urandom % 2) == 1, 32'h1000 + ($urandom % 16),
          ($urandom % 2) == 1, 32'h1000 + ($urandom % 16),
          2'($urandom % 4), ($urandom % 2) == 1, ($urandom % 8) == 0);
    end
    for (int a = 0; a < 6; a++) rd("R2", 3'(a));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule